// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This block is a pipelined integer multiplier with accumulate for a processor's execute stage. It takes two W-bit operands and an operation code. It produces either a truncated W-bit product or a full 2W-bit product. The short forms may add a W-bit addend. The long forms may add a 2W-bit accumulator, supplied as a high word and a low word. The long forms come in signed and unsigned variants. The short forms have no sign variant, because the low W bits of a product do not depend on how the operands are interpreted.

When the caller sets the flag-enable input, the unit also reports a negative flag and a zero flag for the result, each with a write strobe. The surrounding core uses these strobes to update its condition state. Carry and overflow are not computed. Every sum wraps silently.

The unit accepts a new operation on every clock cycle. Each result, with its done pulse, appears two cycles after the start pulse that launched it.

Top module: `mac_unit`

## Requirements
- R1: An operation launched by a start pulse that is sampled at one rising edge raises done for exactly one cycle, after the second following rising edge. Start pulses on consecutive cycles each produce their own done pulse, in the order they were issued.
- R2: Op code 0 (short multiply) gives resLo = (opA*opB) mod 2^W and resHi = 0. The result is the same whatever the sign interpretation of the operands.
- R3: Op code 1 (short accumulate) gives resLo = (opA*opB + addend) mod 2^W and resHi = 0.
- R4: Op code 2 (long unsigned multiply) gives {resHi,resLo} = opA*opB, with both operands read as unsigned.
- R5: Op code 3 (long signed multiply) gives {resHi,resLo} = the two's-complement product of the signed operands.
- R6: Op codes 4 (unsigned) and 5 (signed) give {resHi,resLo} = (product + {accHi,accLo}) mod 2^(2W), with no overflow indication.
- R7: With setFlags high, negWe and zeroWe pulse together with done. negFlag is bit 2W-1 of {resHi,resLo} for long forms and bit W-1 of resLo for short forms.
- R8: For long forms, zeroFlag is 1 only when all 2W result bits are zero. For short forms, it is 1 when the low W bits are zero, even if the full sum carried out.
- R9: With setFlags low, negWe and zeroWe stay low for that operation.
- R10: Op codes 6 and 7 behave exactly like op code 0.
- R11: Reset clears done, both strobes and both result words. The result words hold their last value while no operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 3 | Operation code (see R2 to R6 and R10) |
| setFlags | input | 1 | Request negative/zero flag update |
| opA | input | W | First multiplicand |
| opB | input | W | Second multiplicand |
| addend | input | W | Addend for the short accumulate |
| accHi | input | W | Upper word of the long accumulator |
| accLo | input | W | Lower word of the long accumulator |
| done | output | 1 | Result valid pulse |
| resHi | output | W | Upper result word (zero for short forms) |
| resLo | output | W | Lower result word |
| negFlag | output | 1 | Negative flag value |
| zeroFlag | output | 1 | Zero flag value |
| negWe | output | 1 | Negative flag write strobe |
| zeroWe | output | 1 | Zero flag write strobe |

## Verification
With W = 4, the bench sweeps every operand pair through all eight op codes, and varies the addend, the accumulator and the flag enable.

The sweep targets four kinds of error:
- A design that sign-extends in the unsigned long form, or zero-extends in the signed one, produces a wrong upper word whenever an operand has its top bit set.
- A design that leaks the carry of a short accumulate into resHi, or that tests all 2W bits for the short zero flag, misreports cases such as 4*4 = 16. Directed cases check these.
- Taking the negative flag from the wrong bit for one width flips it on half the sweep.
- Back-to-back issue exposes a pipeline that loses or reorders results, and an idle cycle exposes result words that do not hold.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam logic [2:0] OP_MUL_LO  = 3'd0;
  localparam logic [2:0] OP_MAC_LO  = 3'd1;
  localparam logic [2:0] OP_MUL_U64 = 3'd2;
  localparam logic [2:0] OP_MUL_S64 = 3'd3;
  localparam logic [2:0] OP_MAC_U64 = 3'd4;
  localparam logic [2:0] OP_MAC_S64 = 3'd5;

  typedef struct packed {
    logic valid;
    logic wide;
    logic sgn;
    logic acc;
    logic flags;
  } macStrobes_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic        setFlags,
  output macStrobes_t stb,
  output logic        done,
  output logic        negWe,
  output logic        zeroWe
);
  macStrobes_t decoded;

  always_comb begin
    decoded       = '0;
    decoded.valid = start;
    decoded.flags = setFlags;
    unique case (op)
      OP_MAC_LO:  decoded.acc = 1'b1;
      OP_MUL_U64: decoded.wide = 1'b1;
      OP_MUL_S64: begin decoded.wide = 1'b1; decoded.sgn = 1'b1; end
      OP_MAC_U64: begin decoded.wide = 1'b1; decoded.acc = 1'b1; end
      OP_MAC_S64: begin decoded.wide = 1'b1; decoded.sgn = 1'b1; decoded.acc = 1'b1; end
      default:    ;  // short multiply, also reserved codes
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb    <= '0;
      done   <= 1'b0;
      negWe  <= 1'b0;
      zeroWe <= 1'b0;
    end else begin
      stb    <= decoded;
      done   <= stb.valid;
      negWe  <= stb.valid & stb.flags;
      zeroWe <= stb.valid & stb.flags;
    end
  end
endmodule

// File: rtl/mac_dpath.sv
module mac_dpath
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  macStrobes_t  stb,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] accHi,
  input  logic [W-1:0] accLo,
  output logic [W-1:0] resHi,
  output logic [W-1:0] resLo,
  output logic         negFlag,
  output logic         zeroFlag
);
  localparam int DW = 2 * W;

  logic [W-1:0]  aQ, bQ, addQ, accHiQ, accLoQ;
  logic [DW-1:0] extA, extB, product, accVal, sum, resNext;

  // Operand stage: free-running capture, qualified by stb.valid one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ <= '0; bQ <= '0; addQ <= '0; accHiQ <= '0; accLoQ <= '0;
    end else begin
      aQ <= opA; bQ <= opB; addQ <= addend; accHiQ <= accHi; accLoQ <= accLo;
    end
  end

  always_comb begin
    extA    = {{W{stb.sgn & aQ[W-1]}}, aQ};
    extB    = {{W{stb.sgn & bQ[W-1]}}, bQ};
    product = extA * extB;
    if (!stb.acc)     accVal = '0;
    else if (stb.wide) accVal = {accHiQ, accLoQ};
    else               accVal = {{W{1'b0}}, addQ};
    sum     = product + accVal;
    resNext = stb.wide ? sum : {{W{1'b0}}, sum[W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHi    <= '0;
      resLo    <= '0;
      negFlag  <= 1'b0;
      zeroFlag <= 1'b0;
    end else if (stb.valid) begin
      resHi    <= resNext[DW-1:W];
      resLo    <= resNext[W-1:0];
      negFlag  <= stb.wide ? resNext[DW-1] : resNext[W-1];
      zeroFlag <= (resNext == '0);
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic         setFlags,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] accHi,
  input  logic [W-1:0] accLo,
  output logic         done,
  output logic [W-1:0] resHi,
  output logic [W-1:0] resLo,
  output logic         negFlag,
  output logic         zeroFlag,
  output logic         negWe,
  output logic         zeroWe
);
  macStrobes_t stb;

  mac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .setFlags(setFlags),
    .stb(stb), .done(done), .negWe(negWe), .zeroWe(zeroWe)
  );

  mac_dpath #(.W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .opA(opA), .opB(opB), .addend(addend), .accHi(accHi), .accLo(accLo),
    .resHi(resHi), .resLo(resLo), .negFlag(negFlag), .zeroFlag(zeroFlag)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [2:0]   op,
  input logic         setFlags,
  input logic         done,
  input logic [W-1:0] resHi,
  input logic [W-1:0] resLo,
  input logic         zeroFlag,
  input logic         negWe,
  input logic         zeroWe
);
  logic isLong;
  assign isLong = (op == OP_MUL_U64) || (op == OP_MUL_S64) ||
                  (op == OP_MAC_U64) || (op == OP_MAC_S64);

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    start |=> ##1 done);  // R1

  AST_SHORT_HI_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (start && !isLong) |=> ##1 (resHi == '0));  // R2

  AST_STROBE_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (negWe || zeroWe) |-> (done && negWe && zeroWe));  // R7

  AST_FLAGS_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (start && !setFlags) |=> ##1 (!negWe && !zeroWe));  // R9

  AST_LONG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (start && isLong && setFlags) |=> ##1 (zeroFlag == ({resHi, resLo} == '0)));  // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!done && $past(rstN)) |-> ($stable(resHi) && $stable(resLo)));  // R11
endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .op(op), .setFlags(setFlags),
  .done(done), .resHi(resHi), .resLo(resLo), .zeroFlag(zeroFlag),
  .negWe(negWe), .zeroWe(zeroWe)
);

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int DW = 2 * W;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, setFlags = 1'b0;
  logic [2:0] op = '0;
  logic [W-1:0] opA = '0, opB = '0, addend = '0, accHi = '0, accLo = '0;
  logic done, negFlag, zeroFlag, negWe, zeroWe;
  logic [W-1:0] resHi, resLo;

  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit #(.W(W)) u_mac_unit (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .setFlags(setFlags),
    .opA(opA), .opB(opB), .addend(addend), .accHi(accHi), .accLo(accLo),
    .done(done), .resHi(resHi), .resLo(resLo), .negFlag(negFlag),
    .zeroFlag(zeroFlag), .negWe(negWe), .zeroWe(zeroWe)
  );

  task automatic check(string tag, longint got, longint exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic logic [DW-1:0] model(logic [2:0] o, logic [W-1:0] a, logic [W-1:0] b,
                                          logic [W-1:0] ad, logic [W-1:0] hi, logic [W-1:0] lo);
    longint sa, sb, p, full;
    longint mod2 = longint'(1) << DW;
    longint mod1 = longint'(1) << W;
    sa = a; sb = b;
    if (o == 3'd3 || o == 3'd5) begin
      if (a[W-1]) sa = sa - mod1;
      if (b[W-1]) sb = sb - mod1;
    end
    p = sa * sb;
    case (o)
      3'd1:    full = ((p + ad) % mod1 + mod1) % mod1;
      3'd2, 3'd3: full = (p % mod2 + mod2) % mod2;
      3'd4, 3'd5: full = ((p + ((longint'(hi) << W) | lo)) % mod2 + mod2) % mod2;
      default: full = (p % mod1 + mod1) % mod1;
    endcase
    return full[DW-1:0];
  endfunction

  function automatic string reqOf(logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic runOp(logic [2:0] o, logic [W-1:0] a, logic [W-1:0] b,
                       logic [W-1:0] ad, logic [W-1:0] hi, logic [W-1:0] lo, logic fl);
    logic [DW-1:0] exp;
    logic isLong;
    op = o; opA = a; opB = b; addend = ad; accHi = hi; accLo = lo; setFlags = fl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    exp = model(o, a, b, ad, hi, lo);
    isLong = (o >= 3'd2) && (o <= 3'd5);
    check({reqOf(o), " result"}, {resHi, resLo}, exp);
    check("R1 done", done, 1);
    if (fl) begin
      check("R7 strobes", {negWe, zeroWe}, 2'b11);
      check("R7 neg", negFlag, isLong ? exp[DW-1] : exp[W-1]);
      check("R8 zero", zeroFlag, isLong ? (exp == '0) : (exp[W-1:0] == '0));
    end else begin
      check("R9 strobes off", {negWe, zeroWe}, 2'b00);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [DW-1:0] e1, e2;
    repeat (3) @(negedge clk);
    check("R11 reset done", done, 0);
    check("R11 reset result", {resHi, resLo}, 0);
    check("R11 reset strobes", {negWe, zeroWe}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Exhaustive sweep over all op codes and operand pairs
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          runOp(3'(o), W'(a), W'(b), W'(a * 3 + b), W'(a ^ b), W'(b + 5), 1'((a + b + o) & 1));

    // R8 corner: short sum wraps to zero, and long all-zero
    runOp(3'd0, 4'd4, 4'd4, 4'd0, 4'd0, 4'd0, 1'b1);
    check("R8 short carry zero flag", zeroFlag, 1);
    runOp(3'd1, 4'd3, 4'd5, 4'd1, 4'd0, 4'd0, 1'b1);
    check("R8 short mac wrap zero", {zeroFlag, resHi}, 5'b10000);
    runOp(3'd4, 4'd0, 4'd7, 4'd0, 4'd0, 4'd0, 1'b1);
    check("R8 long zero", zeroFlag, 1);
    runOp(3'd5, 4'd15, 4'd1, 4'd0, 4'd0, 4'd1, 1'b1);
    check("R6 signed wrap to zero", {resHi, resLo}, 0);

    // R1 back-to-back issue, then R11 hold
    op = 3'd3; opA = 4'd9; opB = 4'd3; setFlags = 1'b0; start = 1'b1;
    e1 = model(3'd3, 4'd9, 4'd3, 0, 0, 0);
    @(negedge clk);
    op = 3'd2; opA = 4'd9; opB = 4'd3;
    e2 = model(3'd2, 4'd9, 4'd3, 0, 0, 0);
    @(negedge clk);
    start = 1'b0;
    check("R1 b2b first", {done, resHi, resLo}, {1'b1, e1});
    @(negedge clk);
    check("R1 b2b second", {done, resHi, resLo}, {1'b1, e2});
    @(negedge clk);
    check("R11 idle done", done, 0);
    check("R11 hold", {resHi, resLo}, e2);
    repeat (3) @(negedge clk);
    check("R11 hold later", {resHi, resLo}, e2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule